// File: doc/BRIEF.md
# Exact wide fixed-point dot-product accumulator

This block keeps a running sum of double-precision products without any rounding error. The sum lives in a 4288-bit two's-complement fixed-point register, held as 67 limbs of 64 bits. Each update supplies a 106-bit product magnitude, a sign and a bit position, which the caller has already derived from the exponent sum. The block shifts the magnitude to that position and adds it one limb per cycle, starting at the lowest limb it touches. It passes the carry upward and stops as soon as the remaining limbs can no longer change. Because the register is wide enough to hold every term exactly, the final contents do not depend on the order in which terms arrive.

A second accumulator can be added in as a stream of 67 limbs, least significant first, through a full-width add-with-carry chain. A clear command zeroes the register. A read command streams the 67 limbs out, least significant first. Unpacking the operands, multiplying them and rounding back to floating point are done outside this block.

Top module: `exa_acc`

## Requirements
- R1: After reset, all 67 limbs read as zero, and both `upd_ready_o` and `mrg_ready_o` are high.
- R2: An accepted update with sign 0 adds `mag * 2^pos` to the register modulo 2^4288. Bits that land above bit 4287 are discarded.
- R3: An accepted update with sign 1 subtracts `mag * 2^pos` modulo 2^4288. The borrow is sign-extended through every higher limb it changes.
- R4: After an update is accepted, `upd_ready_o` stays low for one cycle per limb processed. Processing starts at limb `pos/64` and covers at least three limbs. It ends after the first limb, third or later, whose carry-out equals the update's sign-extension bit, or after limb 66. Examples: +x at position 0 into a zero register takes 3 cycles, and −x at position 0 into a zero register takes 67 cycles.
- R5: The final contents are identical for any order in which the same set of updates is applied.
- R6: A merge adds a second 4288-bit value to the register, modulo 2^4288, with the carry running through all limbs. The value arrives as 67 beats on `mrg_limb_i`, least significant first. A beat is taken on each cycle that `mrg_valid_i` is high while `mrg_ready_o` is high.
- R7: When `clr_i` is sampled high in the idle state, all limbs become zero.
- R8: `rd_start_i`, sampled in idle, starts a read. From the next cycle, `rd_valid_o` is high for exactly 67 consecutive cycles. `rd_data_o` carries limb 0 up to limb 66 in that order, and `rd_last_o` is high only with limb 66.
- R9: In idle, one command is taken per cycle, with priority clear, then merge, then update, then read. Lower-priority commands presented in the same cycle are dropped.
- R10: An update whose limb index `pos/64` is 67 or more is dropped. The register keeps its contents and `upd_ready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clear command |
| upd_valid_i | input | 1 | Update request |
| upd_mag_i | input | 106 | Unsigned product magnitude |
| upd_neg_i | input | 1 | Product sign (1 = subtract) |
| upd_pos_i | input | 13 | Bit position of magnitude bit 0 |
| upd_ready_o | output | 1 | Idle, so commands can be taken |
| mrg_valid_i | input | 1 | Merge limb beat valid |
| mrg_limb_i | input | 64 | Merge limb data |
| mrg_ready_o | output | 1 | Merge beats can be taken |
| rd_start_i | input | 1 | Start a limb read stream |
| rd_valid_o | output | 1 | Read limb valid |
| rd_data_o | output | 64 | Read limb data |
| rd_last_o | output | 1 | Final limb of read stream |

## Verification
The assertions rely on three things about the inputs: commands act only in the idle state, a merge that has started is always finished with all 67 beats, and the clear is never sampled while a walk over the limbs is in progress. The stimulus waits for `upd_ready_o` before every command and streams merge beats back to back. Update positions stay inside the 13-bit field, and the only deliberately out-of-range position is the one that checks the drop rule. The bench holds its own 4288-bit reference sum. It compares the streamed-out register against that reference after each scenario, which includes shuffled orderings of a mixed-sign term set and carry or borrow chains that run the full width.

// File: rtl/exa_pkg.sv
package exa_pkg;
   localparam int EXA_LIMB_W = 64;
   localparam int EXA_NLIMBS = 67;
   localparam int EXA_PROD_W = 106;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_UPD  = 2'd1,
      ST_MRG  = 2'd2,
      ST_RD   = 2'd3
   } exa_state_e;
endpackage

// File: rtl/exa_align.sv
module exa_align #(
   parameter int LIMB_W = 64,
   parameter int PROD_W = 106,
   localparam int SPAN_W = 3 * LIMB_W,
   localparam int OFF_W = $clog2(LIMB_W)
) (
   input  logic [PROD_W-1:0] mag_i,
   input  logic              neg_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [SPAN_W-1:0] span_o,
   output logic              ext_o
);
   logic [SPAN_W-1:0] shifted;

   always_comb begin
      shifted = SPAN_W'(mag_i) << off_i;
      ext_o   = neg_i & (|mag_i);
      span_o  = ext_o ? (~shifted + SPAN_W'(1)) : shifted;
   end
endmodule

// File: rtl/exa_limb_add.sv
module exa_limb_add #(
   parameter int LIMB_W = 64
) (
   input  logic [LIMB_W-1:0] a_i,
   input  logic [LIMB_W-1:0] b_i,
   input  logic              cin_i,
   output logic [LIMB_W-1:0] sum_o,
   output logic              cout_o
);
   always_comb begin
      {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{LIMB_W{1'b0}}, cin_i};
   end
endmodule

// File: rtl/exa_limb_bank.sv
module exa_limb_bank #(
   parameter int LIMB_W = 64,
   parameter int N_LIMBS = 67,
   localparam int IDX_W = $clog2(N_LIMBS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [LIMB_W-1:0] wdata_i,
   output logic [LIMB_W-1:0] rdata_o
);
   logic [LIMB_W-1:0] mem_q [N_LIMBS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_LIMBS; i++) mem_q[i] <= '0;
      end else if (clr_i) begin
         for (int i = 0; i < N_LIMBS; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[idx_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[idx_i];

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mem_q[0] == '0 && mem_q[N_LIMBS-1] == '0));
endmodule

// File: rtl/exa_acc.sv
module exa_acc
   import exa_pkg::*;
#(
   parameter int LIMB_W = EXA_LIMB_W,
   parameter int N_LIMBS = EXA_NLIMBS,
   parameter int PROD_W = EXA_PROD_W,
   parameter int POS_W = $clog2(N_LIMBS * LIMB_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              upd_valid_i,
   input  logic [PROD_W-1:0] upd_mag_i,
   input  logic              upd_neg_i,
   input  logic [POS_W-1:0]  upd_pos_i,
   output logic              upd_ready_o,
   input  logic              mrg_valid_i,
   input  logic [LIMB_W-1:0] mrg_limb_i,
   output logic              mrg_ready_o,
   input  logic              rd_start_i,
   output logic              rd_valid_o,
   output logic [LIMB_W-1:0] rd_data_o,
   output logic              rd_last_o
);
   localparam int IDX_W = $clog2(N_LIMBS);
   localparam int OFF_W = $clog2(LIMB_W);
   localparam int SPAN_W = 3 * LIMB_W;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LIMBS - 1);

   generate
      if (PROD_W + LIMB_W - 1 > SPAN_W) begin : g_bad_span
         $error("product does not fit in three limbs");
      end
      if (N_LIMBS < 3) begin : g_bad_depth
         $error("at least three limbs required");
      end
      if ((1 << POS_W) < N_LIMBS * LIMB_W) begin : g_bad_pos
         $error("position field too narrow");
      end
   endgenerate

   exa_state_e            state_q;
   logic [IDX_W-1:0]      idx_q;
   logic [1:0]            k_q;
   logic                  carry_q;
   logic [2:0][LIMB_W-1:0] chunk_q;
   logic                  ext_q;

   logic [SPAN_W-1:0]     span;
   logic                  span_ext;
   logic [31:0]           upd_limb;
   logic                  upd_in_range;

   logic [IDX_W-1:0]      op_idx;
   logic [LIMB_W-1:0]     op_b;
   logic                  op_cin;
   logic                  op_we;
   logic [LIMB_W-1:0]     cur_limb;
   logic [LIMB_W-1:0]     sum;
   logic                  cout;
   logic                  upd_done;
   logic                  bank_clr;

   exa_align #(.LIMB_W(LIMB_W), .PROD_W(PROD_W)) align_i (
      .mag_i (upd_mag_i),
      .neg_i (upd_neg_i),
      .off_i (upd_pos_i[OFF_W-1:0]),
      .span_o(span),
      .ext_o (span_ext)
   );

   assign upd_limb = 32'(upd_pos_i >> OFF_W);
   assign upd_in_range = upd_limb < 32'(N_LIMBS);

   always_comb begin
      op_idx = idx_q;
      op_b   = mrg_limb_i;
      op_cin = carry_q;
      op_we  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            op_idx = '0;
            op_cin = 1'b0;
            op_we  = !clr_i && mrg_valid_i;
         end
         ST_MRG: op_we = mrg_valid_i;
         ST_UPD: begin
            op_we = 1'b1;
            case (k_q)
               2'd0: op_b = chunk_q[0];
               2'd1: op_b = chunk_q[1];
               2'd2: op_b = chunk_q[2];
               default: op_b = {LIMB_W{ext_q}};
            endcase
         end
         default: op_we = 1'b0;
      endcase
   end

   exa_limb_add #(.LIMB_W(LIMB_W)) add_i (
      .a_i   (cur_limb),
      .b_i   (op_b),
      .cin_i (op_cin),
      .sum_o (sum),
      .cout_o(cout)
   );

   assign bank_clr = (state_q == ST_IDLE) && clr_i;

   exa_limb_bank #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (bank_clr),
      .we_i   (op_we),
      .idx_i  (op_idx),
      .wdata_i(sum),
      .rdata_o(cur_limb)
   );

   assign upd_done = (idx_q == LAST) || ((k_q >= 2'd2) && (cout == ext_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         k_q     <= '0;
         carry_q <= 1'b0;
         chunk_q <= '0;
         ext_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (clr_i) begin
                  state_q <= ST_IDLE;
               end else if (mrg_valid_i) begin
                  carry_q <= cout;
                  idx_q   <= IDX_W'(1);
                  state_q <= ST_MRG;
               end else if (upd_valid_i && upd_in_range) begin
                  chunk_q <= span;
                  ext_q   <= span_ext;
                  idx_q   <= IDX_W'(upd_limb);
                  k_q     <= '0;
                  carry_q <= 1'b0;
                  state_q <= ST_UPD;
               end else if (rd_start_i) begin
                  idx_q   <= '0;
                  state_q <= ST_RD;
               end
            end
            ST_UPD: begin
               carry_q <= cout;
               if (upd_done) begin
                  state_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
                  if (k_q != 2'd3) k_q <= k_q + 2'd1;
               end
            end
            ST_MRG: begin
               if (mrg_valid_i) begin
                  carry_q <= cout;
                  if (idx_q == LAST) state_q <= ST_IDLE;
                  else idx_q <= idx_q + IDX_W'(1);
               end
            end
            default: begin
               if (idx_q == LAST) state_q <= ST_IDLE;
               else idx_q <= idx_q + IDX_W'(1);
            end
         endcase
      end
   end

   assign upd_ready_o = (state_q == ST_IDLE);
   assign mrg_ready_o = (state_q == ST_IDLE) || (state_q == ST_MRG);
   assign rd_valid_o  = (state_q == ST_RD);
   assign rd_last_o   = (state_q == ST_RD) && (idx_q == LAST);
   assign rd_data_o   = cur_limb;

   logic [IDX_W:0] upd_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_len_q <= '0;
      else if (state_q == ST_UPD) upd_len_q <= upd_len_q + 1'b1;
      else upd_len_q <= '0;
   end

   // R4
   upd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_ready_o && !clr_i && !mrg_valid_i && upd_valid_i && upd_in_range) |=> !upd_ready_o);
   // R4
   upd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(upd_len_q) <= N_LIMBS);
   // R8
   rd_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_last_o) |=> rd_valid_o);
   // R8
   rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last_o |=> (!rd_valid_o && upd_ready_o));
   // R9
   clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_ready_o && clr_i) |=> upd_ready_o);
   // R10
   drop_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_ready_o && !clr_i && !mrg_valid_i && !rd_start_i && upd_valid_i && !upd_in_range)
      |=> upd_ready_o);
endmodule

// File: tb/exa_acc_tb.sv
module exa_acc_tb_top;
   localparam int W = 64;
   localparam int N = 67;
   localparam int TOT = W * N;
   localparam int PW = 106;
   localparam int PSW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_i = 1'b0;
   logic upd_valid_i = 1'b0;
   logic [PW-1:0] upd_mag_i = '0;
   logic upd_neg_i = 1'b0;
   logic [PSW-1:0] upd_pos_i = '0;
   logic upd_ready_o;
   logic mrg_valid_i = 1'b0;
   logic [W-1:0] mrg_limb_i = '0;
   logic mrg_ready_o;
   logic rd_start_i = 1'b0;
   logic rd_valid_o;
   logic [W-1:0] rd_data_o;
   logic rd_last_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [TOT-1:0] model = '0;

   always #4 clk = ~clk;

   exa_acc dut_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
      .upd_valid_i(upd_valid_i), .upd_mag_i(upd_mag_i), .upd_neg_i(upd_neg_i),
      .upd_pos_i(upd_pos_i), .upd_ready_o(upd_ready_o),
      .mrg_valid_i(mrg_valid_i), .mrg_limb_i(mrg_limb_i), .mrg_ready_o(mrg_ready_o),
      .rd_start_i(rd_start_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
      .rd_last_o(rd_last_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk_int(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_upd(input logic [PW-1:0] mag, input logic neg,
                         input logic [PSW-1:0] pos, output int busy);
      logic [TOT-1:0] t;
      @(negedge clk);
      while (!upd_ready_o) @(negedge clk);
      upd_valid_i = 1'b1; upd_mag_i = mag; upd_neg_i = neg; upd_pos_i = pos;
      @(negedge clk);
      upd_valid_i = 1'b0;
      busy = 0;
      while (!upd_ready_o) begin busy++; @(negedge clk); end
      if (32'(pos) < TOT) begin
         t = TOT'(mag) << pos;
         model = neg ? model - t : model + t;
      end
   endtask

   task automatic do_clear();
      @(negedge clk);
      while (!upd_ready_o) @(negedge clk);
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      model = '0;
   endtask

   task automatic do_merge(input logic [TOT-1:0] v);
      @(negedge clk);
      while (!upd_ready_o) @(negedge clk);
      for (int i = 0; i < N; i++) begin
         mrg_valid_i = 1'b1;
         mrg_limb_i = v[i*W +: W];
         @(negedge clk);
      end
      mrg_valid_i = 1'b0;
      model = model + v;
   endtask

   task automatic read_all(input string tag, output logic [TOT-1:0] img);
      int vbad = 0;
      int lbad = 0;
      @(negedge clk);
      while (!upd_ready_o) @(negedge clk);
      rd_start_i = 1'b1;
      @(negedge clk);
      rd_start_i = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!rd_valid_o) vbad++;
         if (rd_last_o != (i == N - 1)) lbad++;
         img[i*W +: W] = rd_data_o;
         @(negedge clk);
      end
      chk_int({tag, " R8 valid gaps"}, vbad, 0);
      chk_int({tag, " R8 last flag errors"}, lbad, 0);
      chk_int({tag, " R8 valid after stream"}, longint'(rd_valid_o), 0);
   endtask

   task automatic chk_model(input string tag);
      logic [TOT-1:0] img;
      read_all(tag, img);
      total++;
      if (img !== model) begin
         bad++;
         $display("FAIL %s: actual top=%h low=%h expected top=%h low=%h", tag,
                  img[TOT-1 -: W], img[W-1:0], model[TOT-1 -: W], model[W-1:0]);
      end
   endtask

   task automatic t_reset();
      chk_int("R1 upd_ready after reset", longint'(upd_ready_o), 1);
      chk_int("R1 mrg_ready after reset", longint'(mrg_ready_o), 1);
      chk_model("R1 contents after reset");
   endtask

   task automatic t_busy_sign();
      int b;
      do_clear();
      do_upd(PW'(5), 1'b0, '0, b);
      chk_int("R4 positive into zero busy", b, 3);
      chk_model("R2 small positive");
      do_clear();
      do_upd(PW'(5), 1'b1, '0, b);
      chk_int("R4 negative into zero busy", b, 67);
      chk_model("R3 negative sign extends");
      do_upd(PW'(5), 1'b0, '0, b);
      chk_int("R4 full carry chain busy", b, 67);
      chk_model("R3 cancel to zero");
   endtask

   task automatic t_wide();
      int b;
      do_clear();
      do_upd({PW{1'b1}}, 1'b0, PSW'(1000), b);
      do_upd({PW{1'b1}}, 1'b0, PSW'(1000), b);
      do_upd({PW{1'b1}}, 1'b0, PSW'(4250), b);
      chk_model("R2 wide values and top truncation");
      do_upd({1'b1, {(PW-1){1'b0}}}, 1'b1, PSW'(63), b);
      chk_model("R3 borrow across limbs");
   endtask

   task automatic t_order();
      logic [TOT-1:0] r1, r2, r3;
      int b;
      for (int pass = 0; pass < 3; pass++) begin
         do_clear();
         for (int j = 0; j < 8; j++) begin
            int i;
            logic [63:0] lo;
            i = (pass == 0) ? j : (pass == 1) ? (7 - j) : ((j * 3) % 8);
            lo = 64'(i + 1) * 64'h9e37_79b9_7f4a_7c15;
            do_upd({{(PW-64){1'b1}}, lo}, i[0], PSW'((i * 613) % 4200), b);
         end
         if (pass == 0) read_all("R5 order A", r1);
         else if (pass == 1) read_all("R5 order B", r2);
         else read_all("R5 order C", r3);
      end
      total++;
      if (r1 !== r2 || r1 !== r3) begin
         bad++;
         $display("FAIL R5 orders differ: actual low=%h/%h expected low=%h",
                  r2[W-1:0], r3[W-1:0], r1[W-1:0]);
      end
      total++;
      if (r1 !== model) begin
         bad++;
         $display("FAIL R5 vs reference: actual low=%h expected low=%h", r1[W-1:0], model[W-1:0]);
      end
   endtask

   task automatic t_merge();
      logic [TOT-1:0] v;
      int b;
      do_clear();
      do_upd({PW{1'b1}}, 1'b1, PSW'(0), b);
      v = '0;
      v[200 +: 40] = 40'hab_cdef_0123;
      do_merge(v);
      chk_model("R6 merge with full borrow chain");
      v = {TOT{1'b1}};
      do_merge(v);
      chk_model("R6 merge all ones");
   endtask

   task automatic t_clear_prio();
      int b;
      do_upd(PW'(77), 1'b0, PSW'(300), b);
      @(negedge clk);
      while (!upd_ready_o) @(negedge clk);
      clr_i = 1'b1; upd_valid_i = 1'b1; upd_mag_i = PW'(9); upd_neg_i = 1'b0; upd_pos_i = '0;
      @(negedge clk);
      clr_i = 1'b0; upd_valid_i = 1'b0;
      model = '0;
      chk_int("R9 ready after clear with update", longint'(upd_ready_o), 1);
      chk_model("R7 clear zeroes and R9 update dropped");
   endtask

   task automatic t_far();
      int b;
      do_upd(PW'(3), 1'b0, PSW'(64), b);
      do_upd({PW{1'b1}}, 1'b0, PSW'(TOT), b);
      chk_int("R10 far position busy", b, 0);
      do_upd({PW{1'b1}}, 1'b1, PSW'(8191), b);
      chk_int("R10 max position busy", b, 0);
      chk_model("R10 contents unchanged");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_busy_sign();
      t_wide();
      t_order();
      t_merge();
      t_clear_prio();
      t_far();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule